// File: doc/BRIEF.md
# Program-Store Data Window Mapper

This block lets a processor read constant tables held in its 24-bit program store with ordinary data loads. Every load request on the data side is examined. A request below the midpoint of the 64 KB data space (address bit 15 clear) is steered to normal data memory. A request above the midpoint is not sent to data memory. Instead, the block forms a 23-bit program-store address from an 8-bit window page register and the low data address bits, issues one program-store read, and hands back the low 16 bits of the returned word, or one byte of them.

A windowed load costs one extra cycle. In the cycle after the request is accepted, the block raises `stall` and drives the program-store read. The synchronous store answers on the next edge. The block then presents the result on `rsp_data` with `rsp_valid` for one cycle. A normal data load completes one cycle after its request, in data memory outside this block. A windowed load completes two cycles after its request.

The sequencer has three states:
- **ST_IDLE**: no windowed load in flight.
- **ST_FETCH**: the program-store read is on the port and the requester is stalled.
- **ST_DELIVER**: the result is on the response port.

It has five transitions:
- **T_ACCEPT**: ST_IDLE to ST_FETCH, on a windowed request.
- **T_WAIT**: ST_IDLE stays in ST_IDLE when there is no windowed request.
- **T_READ**: ST_FETCH to ST_DELIVER, always.
- **T_CHAIN**: ST_DELIVER to ST_FETCH, on a windowed request.
- **T_DONE**: ST_DELIVER to ST_IDLE otherwise.

Top module: `psv_window_mapper`

## Requirements
- R1: A valid request with address bit 15 clear raises `dm_sel` in the same cycle, and does not raise `pm_rd` or `stall` in the following cycle. The exception is R9.
- R2: A valid request with address bit 15 set is accepted. In the next cycle, `pm_rd` is high and `pm_addr` equals {page, req_addr[14:1], 1'b0}, where page is the page register value in the cycle of acceptance.
- R3: Whenever `pm_rd` is high, bit 0 of `pm_addr` is 0.
- R4: Each accepted windowed request raises `stall` for exactly one cycle: the cycle after acceptance.
- R5: In the cycle after the stall, `rsp_valid` is high for one cycle. For a word load, `rsp_data` equals bits [15:0] of the program word, and bits [23:16] are discarded. `rsp_data` is 0 whenever `rsp_valid` is low.
- R6: For a byte load (`req_byte` = 1), `rsp_data` is {8'h00, word[7:0]} when req_addr[0] = 0, and {8'h00, word[15:8]} when req_addr[0] = 1.
- R7: After reset, the page register is 0 and `stall`, `pm_rd`, `rsp_valid` and `rsp_data` are 0.
- R8: A page write in the same cycle as an accepted windowed request does not affect that request. It applies to every request accepted afterwards.
- R9: A request presented while `stall` is high is ignored. It raises neither `dm_sel` nor a second stall.
- R10: A windowed request presented while `rsp_valid` is high is accepted. Back-to-back windowed loads therefore complete every two cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Data load request valid |
| req_addr | input | 16 | Data byte address |
| req_byte | input | 1 | 1 = byte load, 0 = word load |
| page_we | input | 1 | Page register write enable |
| page_wdata | input | 8 | New page register value |
| dm_sel | output | 1 | Request goes to normal data memory |
| stall | output | 1 | Requester must hold off this cycle |
| pm_rd | output | 1 | Program-store read strobe |
| pm_addr | output | 23 | Program-store address |
| pm_rdata | input | 24 | Program-store word, valid the cycle after `pm_rd` |
| rsp_valid | output | 1 | Windowed load result valid |
| rsp_data | output | 16 | Windowed load result |

## Verification
The bench interleaves lower-half and upper-half loads to separate the two routing paths. It sweeps byte loads at even and odd addresses against word loads, so that a wrong lane choice or a missing zero-extension shows in the data. Requests held through the stall cycle and continuous windowed streams separate correct ignoring (R9) from correct chaining (R10). Page writes that coincide with a request expose whether the address is captured with the old page or the new one. A long stretch of random traffic follows, with the program-store contents derived from the address so that every address bit reaches the returned data.

// File: rtl/psv_pkg.sv
package psv_pkg;
    typedef enum logic [1:0] {
        ST_IDLE    = 2'd0,
        ST_FETCH   = 2'd1,
        ST_DELIVER = 2'd2
    } psv_state_t;
endpackage

// File: rtl/psv_page_reg.sv
module psv_page_reg #(
    parameter int PAGE_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              we,
    input  logic [PAGE_W-1:0] wdata,
    output logic [PAGE_W-1:0] page
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)  page <= '0;
        else if (we) page <= wdata;
    end
endmodule

// File: rtl/psv_req_capture.sv
module psv_req_capture #(
    parameter int DATA_AW = 16,
    parameter int PAGE_W  = 8
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       load,
    input  logic [DATA_AW-1:0]         addr,
    input  logic                       is_byte,
    input  logic [PAGE_W-1:0]          page,
    output logic [PAGE_W+DATA_AW-2:0]  pm_addr_q,
    output logic                       byte_q,
    output logic                       hi_q
);
    localparam int OFS_W = DATA_AW - 1;
    localparam int PM_AW = PAGE_W + OFS_W;

    // Even program address: page on top, word index below, bit 0 forced clear.
    logic [PM_AW-1:0] pm_addr_d;
    assign pm_addr_d = {page, addr[OFS_W-1:1], 1'b0};

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pm_addr_q <= '0;
            byte_q    <= 1'b0;
            hi_q      <= 1'b0;
        end else if (load) begin
            pm_addr_q <= pm_addr_d;
            byte_q    <= is_byte;
            hi_q      <= addr[0];
        end
    end
endmodule

// File: rtl/psv_lane_sel.sv
module psv_lane_sel #(
    parameter int PM_DW = 24,
    parameter int DW    = 16
) (
    input  logic [PM_DW-1:0] word,
    input  logic             is_byte,
    input  logic             hi,
    output logic [DW-1:0]    data
);
    localparam int BW     = DW / 2;
    localparam int LANES  = DW / BW;

    logic [BW-1:0] lane [LANES];

    for (genvar g = 0; g < LANES; g++) begin : g_lane
        assign lane[g] = word[g*BW +: BW];
    end

    always_comb begin
        if (is_byte) data = {{(DW-BW){1'b0}}, (hi ? lane[1] : lane[0])};
        else         data = word[DW-1:0];
    end
endmodule

// File: rtl/psv_window_mapper.sv
module psv_window_mapper
    import psv_pkg::*;
#(
    parameter int DATA_AW = 16,
    parameter int PAGE_W  = 8,
    parameter int PM_DW   = 24,
    parameter int DW      = 16,
    localparam int PM_AW  = PAGE_W + DATA_AW - 1
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               req_valid,
    input  logic [DATA_AW-1:0] req_addr,
    input  logic               req_byte,
    input  logic               page_we,
    input  logic [PAGE_W-1:0]  page_wdata,
    output logic               dm_sel,
    output logic               stall,
    output logic               pm_rd,
    output logic [PM_AW-1:0]   pm_addr,
    input  logic [PM_DW-1:0]   pm_rdata,
    output logic               rsp_valid,
    output logic [DW-1:0]      rsp_data
);
    localparam int WIN_BIT = DATA_AW - 1;

    psv_state_t state_q, state_d;
    logic [PAGE_W-1:0] page;
    logic              open_slot;
    logic              accept;
    logic              byte_q, hi_q;
    logic [DW-1:0]     lane_data;

    assign open_slot = (state_q != ST_FETCH);
    assign accept    = open_slot && req_valid && req_addr[WIN_BIT];

    psv_page_reg #(.PAGE_W(PAGE_W)) u_page (
        .clk   (clk),
        .rst_n (rst_n),
        .we    (page_we),
        .wdata (page_wdata),
        .page  (page)
    );

    psv_req_capture #(.DATA_AW(DATA_AW), .PAGE_W(PAGE_W)) u_cap (
        .clk       (clk),
        .rst_n     (rst_n),
        .load      (accept),
        .addr      (req_addr),
        .is_byte   (req_byte),
        .page      (page),
        .pm_addr_q (pm_addr),
        .byte_q    (byte_q),
        .hi_q      (hi_q)
    );

    psv_lane_sel #(.PM_DW(PM_DW), .DW(DW)) u_lane (
        .word    (pm_rdata),
        .is_byte (byte_q),
        .hi      (hi_q),
        .data    (lane_data)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:    state_d = accept ? ST_FETCH : ST_IDLE;     // T_ACCEPT / T_WAIT
            ST_FETCH:   state_d = ST_DELIVER;                      // T_READ
            ST_DELIVER: state_d = accept ? ST_FETCH : ST_IDLE;     // T_CHAIN / T_DONE
            default:    state_d = ST_IDLE;
        endcase
    end

    always_comb begin
        stall     = 1'b0;
        pm_rd     = 1'b0;
        rsp_valid = 1'b0;
        rsp_data  = '0;
        dm_sel    = open_slot && req_valid && !req_addr[WIN_BIT];
        unique case (state_q)
            ST_IDLE: ;
            ST_FETCH: begin
                stall = 1'b1;
                pm_rd = 1'b1;
            end
            ST_DELIVER: begin
                rsp_valid = 1'b1;
                rsp_data  = lane_data;
            end
            default: ;
        endcase
    end
endmodule

// File: rtl/psv_window_mapper_chk.sv
module psv_window_mapper_chk #(
    parameter int DATA_AW = 16,
    parameter int PAGE_W  = 8,
    parameter int PM_DW   = 24,
    parameter int DW      = 16,
    localparam int PM_AW  = PAGE_W + DATA_AW - 1
) (
    input logic               clk,
    input logic               rst_n,
    input logic               req_valid,
    input logic [DATA_AW-1:0] req_addr,
    input logic               dm_sel,
    input logic               stall,
    input logic               pm_rd,
    input logic [PM_AW-1:0]   pm_addr,
    input logic               rsp_valid,
    input logic [DW-1:0]      rsp_data
);
    // R4
    stall_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        stall |=> !stall);

    // R4
    stall_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(stall) |-> $past(req_valid && req_addr[DATA_AW-1]));

    // R5
    result_follows_chk: assert property (@(posedge clk) disable iff (!rst_n)
        stall |=> rsp_valid);

    // R5
    result_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |-> $past(pm_rd));

    // R5
    idle_data_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !rsp_valid |-> (rsp_data == '0));

    // R3
    even_pm_chk: assert property (@(posedge clk) disable iff (!rst_n)
        pm_rd |-> (pm_addr[0] == 1'b0));

    // R9
    no_route_in_stall_chk: assert property (@(posedge clk) disable iff (!rst_n)
        stall |-> !dm_sel);

    // R1
    low_no_fetch_chk: assert property (@(posedge clk) disable iff (!rst_n)
        dm_sel |=> !stall);
endmodule

bind psv_window_mapper psv_window_mapper_chk #(
    .DATA_AW(DATA_AW), .PAGE_W(PAGE_W), .PM_DW(PM_DW), .DW(DW)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .req_valid (req_valid),
    .req_addr  (req_addr),
    .dm_sel    (dm_sel),
    .stall     (stall),
    .pm_rd     (pm_rd),
    .pm_addr   (pm_addr),
    .rsp_valid (rsp_valid),
    .rsp_data  (rsp_data)
);

// File: tb/psv_window_mapper_test.sv
`timescale 1ns/1ps
module psv_window_mapper_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic [15:0] req_addr = '0;
    logic        req_byte = 1'b0;
    logic        page_we = 1'b0;
    logic [7:0]  page_wdata = '0;
    logic        dm_sel, stall, pm_rd, rsp_valid;
    logic [22:0] pm_addr;
    logic [23:0] pm_rdata = '0;
    logic [15:0] rsp_data;

    int checks = 0;
    int errors = 0;
    int cycles = 0;

    always #2.5 clk = ~clk;

    psv_window_mapper uut (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_addr(req_addr),
        .req_byte(req_byte), .page_we(page_we), .page_wdata(page_wdata),
        .dm_sel(dm_sel), .stall(stall), .pm_rd(pm_rd), .pm_addr(pm_addr),
        .pm_rdata(pm_rdata), .rsp_valid(rsp_valid), .rsp_data(rsp_data)
    );

    function automatic logic [23:0] pm_word(input logic [22:0] a);
        return {a[22:15], a[15:0] ^ {a[7:0], a[22:15]} ^ 16'hA55A};
    endfunction

    // Program store: synchronous read, one cycle latency
    always @(posedge clk) if (pm_rd) pm_rdata <= pm_word(pm_addr);

    always @(posedge clk) begin
        cycles <= cycles + 1;
        if (cycles > 20000) begin
            errors = errors + 1;
            $display("FAIL watchdog all-R: act=%0d cycles exp<=20000", cycles);
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    // Reference model state
    int          m_phase = 0;   // 0 idle, 1 fetch, 2 deliver
    logic [7:0]  m_page = '0;
    logic [22:0] m_pa = '0;
    logic        m_byte = 1'b0;
    logic        m_hi = 1'b0;

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: act=%h exp=%h at cycle %0d", req, act, exp, cycles);
        end
    endtask

    function automatic logic [15:0] lane(input logic [23:0] w, input logic b, input logic h);
        if (!b) return w[15:0];
        return h ? {8'h00, w[15:8]} : {8'h00, w[7:0]};
    endfunction

    task automatic step(input logic v, input logic [15:0] a, input logic b,
                        input logic pwe, input logic [7:0] pd, input string tag);
        logic e_dm;
        @(negedge clk);
        req_valid = v; req_addr = a; req_byte = b; page_we = pwe; page_wdata = pd;
        #1;
        e_dm = v && !a[15] && (m_phase != 1);
        chk({"R1 R9 dm_sel ", tag}, dm_sel, e_dm);
        chk({"R4 stall ", tag}, stall, m_phase == 1);
        chk({"R2 pm_rd ", tag}, pm_rd, m_phase == 1);
        if (m_phase == 1) begin
            chk({"R2 R8 pm_addr ", tag}, pm_addr, m_pa);
            chk({"R3 pm_addr bit0 ", tag}, pm_addr[0], 1'b0);
        end
        chk({"R5 rsp_valid ", tag}, rsp_valid, m_phase == 2);
        chk({"R5 R6 rsp_data ", tag}, rsp_data,
            (m_phase == 2) ? lane(pm_word(m_pa), m_byte, m_hi) : 16'h0);
        @(posedge clk);
        if (m_phase == 1) m_phase = 2;
        else if (v && a[15]) begin
            m_phase = 1;
            m_pa = {m_page, a[14:1], 1'b0};
            m_byte = b;
            m_hi = a[0];
        end else m_phase = 0;
        if (pwe) m_page = pd;
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) step(1'b0, 16'h0, 1'b0, 1'b0, 8'h0, "idle");
    endtask

    initial begin
        #12;
        // R7: reset state
        chk("R7 stall at reset", stall, 0);
        chk("R7 pm_rd at reset", pm_rd, 0);
        chk("R7 rsp_valid at reset", rsp_valid, 0);
        chk("R7 rsp_data at reset", rsp_data, 0);
        @(negedge clk); rst_n = 1'b1;

        // R1: lower half pass-through
        step(1'b1, 16'h1234, 1'b0, 1'b0, 8'h0, "R1 low word");
        step(1'b1, 16'h7FFF, 1'b1, 1'b0, 8'h0, "R1 low top");
        idle(2);
        // R7: page 0 after reset, R2/R5 word read
        step(1'b1, 16'h8000, 1'b0, 1'b0, 8'h0, "R7 page0");
        idle(3);
        step(1'b0, 16'h0, 1'b0, 1'b1, 8'h5A, "page write");
        step(1'b1, 16'hC002, 1'b0, 1'b0, 8'h0, "R2 paged word");
        idle(3);
        // R6: byte lanes
        step(1'b1, 16'h8003, 1'b1, 1'b0, 8'h0, "R6 hi byte");
        idle(3);
        step(1'b1, 16'h9000, 1'b1, 1'b0, 8'h0, "R6 lo byte");
        idle(3);
        step(1'b1, 16'hFFFF, 1'b0, 1'b0, 8'h0, "R3 odd word addr");
        idle(3);
        // R9: requests during stall ignored
        step(1'b1, 16'hA010, 1'b0, 1'b0, 8'h0, "R9 first");
        step(1'b1, 16'hFFFE, 1'b0, 1'b0, 8'h0, "R9 in stall high");
        step(1'b0, 16'h0, 1'b0, 1'b0, 8'h0, "R9 after");
        step(1'b1, 16'hB020, 1'b0, 1'b0, 8'h0, "R9 second");
        step(1'b1, 16'h0010, 1'b0, 1'b0, 8'h0, "R9 in stall low");
        idle(3);
        // R8: page write coinciding with request
        step(1'b1, 16'h8100, 1'b0, 1'b1, 8'hC3, "R8 same cycle");
        idle(2);
        step(1'b1, 16'h8100, 1'b0, 1'b0, 8'h0, "R8 after write");
        idle(3);
        // R10: continuous windowed stream
        for (int i = 0; i < 8; i++)
            step(1'b1, 16'h8000 + 16'(i * 6), i[0], 1'b0, 8'h0, "R10 chain");
        idle(3);
        // Random mix
        for (int i = 0; i < 400; i++)
            step(1'($urandom), 16'($urandom), 1'($urandom),
                 ($urandom % 8) == 0, 8'($urandom), "random");
        idle(3);
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule